// File: doc/BRIEF.md
# Rolling-Shutter Row Sequencer

This block generates the per-line control timing for a pixel array whose rows are addressed directly over a shared address bus. Each line period starts by driving the read row onto the bus and strobing it into the array's row decoder with an active-low load pulse. A double-sample burst follows: sample-signal high, then row reset high, then sample-reset high, with programmable gaps between them. The block then drives a second row, the lead row, onto the same bus. It strobes that row and pulses reset on it, which starts the row's exposure. The distance between the lead row and the read row sets the integration time.

A frame is started by a one-cycle request while the sequencer is idle. At that edge it captures all window and timing settings. The read row starts at the window start and advances by the row step. The frame ends after the last row that does not exceed the window end. After each line the block raises a done flag toward the column readout logic. It waits for that logic to acknowledge before starting the next line. During the first line of a frame a calibration pulse is produced at a programmable offset from the rise of the sample-signal pulse. All widths and delays are counted in clock cycles.

Top module: `rowseq_top`

## Requirements
- R1: During and after reset the block is idle: row load strobe high (inactive), sample-signal, row reset, sample-reset, calibration and line-done low, row address 0. The column acknowledge has no effect while idle.
- R2: A frame request is accepted only while idle. A request raised at any time during a frame has no effect on the outputs.
- R3: Each line begins with one cycle in which the read row is on the address bus and the load strobe is high. The strobe is then low for the load length. One more cycle follows with the strobe high and the same address.
- R4: After the read-row strobe, sample-signal is high for the sample length, then all pulses are low for the gap length, then row reset is high for the reset length, then the gap length again, then sample-reset is high for the sample length.
- R5: After sample-reset falls, the lead row is driven for one cycle with the strobe high, then the strobe is low for the load length, then high for one cycle, then the gap length, then row reset is high for the reset length, then the gap length once more.
- R6: The lead row equals the read row plus the lead offset. When that sum exceeds the window end, it is reduced by the window span (end minus start plus one). The offset must not exceed the span.
- R7: The read row starts at the window start and advances by the row step. The frame ends after the line whose row plus the step exceeds the window end. The block then returns to idle, and the bus keeps the last read row.
- R8: After each line's lead-row sequence, line-done is high, with all pulses low and the read row on the bus, until the column acknowledge is seen high at a clock edge. The next line begins in the following cycle.
- R9: In the first line of a frame only, the calibration output is high for the calibration length. It starts the calibration delay cycles after the cycle in which sample-signal rises (a delay of 0 makes it coincide).
- R10: Window, step, offset and all timing settings are captured when a frame is accepted. Changes to those inputs during the frame have no effect until the next accepted frame.
- R11: A load, sample, gap, reset or calibration length of 0, or a row step of 0, behaves as 1.
- R12: At most one of load strobe low, sample-signal, row reset and sample-reset is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameStart | input | 1 | One-cycle frame request, honoured only while idle |
| columnDone | input | 1 | Acknowledge from column readout, ends the line-done wait |
| winStart | input | 10 | First read row of the window |
| winEnd | input | 10 | Highest row the window may reach |
| rowStep | input | 10 | Read-row increment per line |
| leadOffset | input | 10 | Rows between the read row and the lead row |
| loadCycles | input | 8 | Load strobe low time |
| sampleCycles | input | 8 | Width of each sample pulse |
| gapCycles | input | 8 | Quiet time around each row reset pulse |
| resetCycles | input | 8 | Row reset pulse width |
| calDelay | input | 8 | Calibration start after sample-signal rise |
| calCycles | input | 8 | Calibration pulse width |
| rowAddr | output | 10 | Shared row address bus |
| rowLoadN | output | 1 | Active-low row address load strobe |
| sampleS | output | 1 | Signal-level sample pulse |
| rowReset | output | 1 | Row reset pulse |
| sampleR | output | 1 | Reset-level sample pulse |
| calPulse | output | 1 | Once-per-frame calibration pulse |
| lineDone | output | 1 | Line finished, waiting for the column acknowledge |

## Verification
The hardest case to reach is the lead-row wrap. It needs an offset large enough that the read row plus the offset passes the window end, and the step must not be 1, so that the wrap subtracts a span that differs from the stride. The stimulus sweeps every offset from 0 up to the full span of a small window for three step sizes, and adds a frame at the top of the address range. In every accepted frame the setting inputs are overwritten right after acceptance, so any use of live rather than captured settings shows up as a wrong address or pulse width.

// File: rtl/rowseq_pkg.sv
package rowseq_pkg;
  parameter int ROW_AW = 10;
  parameter int TIM_W  = 8;

  typedef struct packed {
    logic [ROW_AW-1:0] winLo;
    logic [ROW_AW-1:0] winHi;
    logic [ROW_AW-1:0] rowStep;
    logic [ROW_AW-1:0] leadOff;
    logic [TIM_W-1:0]  loadLen;
    logic [TIM_W-1:0]  sLen;
    logic [TIM_W-1:0]  gapLen;
    logic [TIM_W-1:0]  rstLen;
    logic [TIM_W-1:0]  calDly;
    logic [TIM_W-1:0]  calLen;
  } seqCfg_t;

  typedef struct packed {
    logic capture;   // frame accepted this cycle
    logic advance;   // move to next read row
    logic selLead;   // bus shows lead row
    logic calStart;  // first S cycle of the first line
  } seqStrobe_t;

  typedef enum logic [3:0] {
    PH_IDLE, PH_RD_SET, PH_RD_LD, PH_RD_HLD, PH_S_HI, PH_GAP_A, PH_RST_A,
    PH_GAP_B, PH_R_HI, PH_LR_SET, PH_LR_LD, PH_LR_HLD, PH_LR_GAP, PH_LR_RST,
    PH_LR_TAIL, PH_WAIT_COL
  } seqPhase_t;
endpackage

// File: rtl/rowseq_ctrl.sv
module rowseq_ctrl
  import rowseq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameStart,
  input  logic             columnDone,
  input  logic             lastLine,
  input  logic [TIM_W-1:0] loadLen,
  input  logic [TIM_W-1:0] sLen,
  input  logic [TIM_W-1:0] gapLen,
  input  logic [TIM_W-1:0] rstLen,
  output seqStrobe_t       strb,
  output logic             rowLoadN,
  output logic             sampleS,
  output logic             rowReset,
  output logic             sampleR,
  output logic             lineDone
);
  seqPhase_t phaseQ, phaseNext;
  logic [TIM_W-1:0] cntQ, phaseLen;
  logic firstQ, phaseEnd;

  always_comb begin
    case (phaseQ)
      PH_RD_LD, PH_LR_LD:                         phaseLen = loadLen;
      PH_S_HI, PH_R_HI:                           phaseLen = sLen;
      PH_GAP_A, PH_GAP_B, PH_LR_GAP, PH_LR_TAIL:  phaseLen = gapLen;
      PH_RST_A, PH_LR_RST:                        phaseLen = rstLen;
      default:                                    phaseLen = TIM_W'(1);
    endcase
  end

  assign phaseEnd = (cntQ == phaseLen - TIM_W'(1));

  always_comb begin
    case (phaseQ)
      PH_IDLE:     phaseNext = frameStart ? PH_RD_SET : PH_IDLE;
      PH_WAIT_COL: phaseNext = columnDone ? (lastLine ? PH_IDLE : PH_RD_SET) : PH_WAIT_COL;
      default:     phaseNext = phaseEnd ? seqPhase_t'(phaseQ + 4'd1) : phaseQ;
    endcase
  end

  assign strb.capture  = (phaseQ == PH_IDLE) && frameStart;
  assign strb.advance  = (phaseQ == PH_WAIT_COL) && columnDone && !lastLine;
  assign strb.selLead  = (phaseQ inside {PH_LR_SET, PH_LR_LD, PH_LR_HLD, PH_LR_GAP,
                                         PH_LR_RST, PH_LR_TAIL});
  assign strb.calStart = (phaseQ == PH_S_HI) && (cntQ == '0) && firstQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ <= PH_IDLE;
      cntQ   <= '0;
      firstQ <= 1'b0;
    end else begin
      phaseQ <= phaseNext;
      if (phaseNext != phaseQ || phaseQ == PH_IDLE || phaseQ == PH_WAIT_COL)
        cntQ <= '0;
      else
        cntQ <= cntQ + TIM_W'(1);
      if (strb.capture)      firstQ <= 1'b1;
      else if (strb.advance) firstQ <= 1'b0;
    end
  end

  assign rowLoadN = !((phaseQ == PH_RD_LD) || (phaseQ == PH_LR_LD));
  assign sampleS  = (phaseQ == PH_S_HI);
  assign rowReset = (phaseQ == PH_RST_A) || (phaseQ == PH_LR_RST);
  assign sampleR  = (phaseQ == PH_R_HI);
  assign lineDone = (phaseQ == PH_WAIT_COL);
endmodule

// File: rtl/rowseq_dp.sv
module rowseq_dp
  import rowseq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  seqCfg_t           cfgIn,
  output logic              lastLine,
  output logic [ROW_AW-1:0] rowAddr,
  output logic              calPulse,
  output logic [TIM_W-1:0]  loadLen,
  output logic [TIM_W-1:0]  sLen,
  output logic [TIM_W-1:0]  gapLen,
  output logic [TIM_W-1:0]  rstLen,
  output logic [ROW_AW-1:0] winLo,
  output logic [ROW_AW-1:0] winHi
);
  localparam int SW = ROW_AW + 1;
  localparam int CW = TIM_W + 1;

  seqCfg_t cfgQ, cfgFix;
  logic [ROW_AW-1:0] readRowQ;
  logic [SW-1:0] nextRow, span, leadSum;
  logic [CW-1:0] calCntQ, calT, calLim;
  logic calRunQ;

  function automatic logic [TIM_W-1:0] atLeastOne(input logic [TIM_W-1:0] v);
    return (v == '0) ? TIM_W'(1) : v;
  endfunction

  always_comb begin
    cfgFix         = cfgIn;
    cfgFix.rowStep = (cfgIn.rowStep == '0) ? ROW_AW'(1) : cfgIn.rowStep;
    cfgFix.loadLen = atLeastOne(cfgIn.loadLen);
    cfgFix.sLen    = atLeastOne(cfgIn.sLen);
    cfgFix.gapLen  = atLeastOne(cfgIn.gapLen);
    cfgFix.rstLen  = atLeastOne(cfgIn.rstLen);
    cfgFix.calLen  = atLeastOne(cfgIn.calLen);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ     <= '0;
      readRowQ <= '0;
    end else if (strb.capture) begin
      cfgQ     <= cfgFix;
      readRowQ <= cfgIn.winLo;
    end else if (strb.advance) begin
      readRowQ <= readRowQ + cfgQ.rowStep;
    end
  end

  // row stepping and lead-row wrap inside the window
  assign nextRow  = {1'b0, readRowQ} + {1'b0, cfgQ.rowStep};
  assign lastLine = nextRow > {1'b0, cfgQ.winHi};
  assign span     = {1'b0, cfgQ.winHi} - {1'b0, cfgQ.winLo} + SW'(1);
  assign leadSum  = {1'b0, readRowQ} + {1'b0, cfgQ.leadOff};
  assign rowAddr  = strb.selLead
                  ? ROW_AW'((leadSum > {1'b0, cfgQ.winHi}) ? leadSum - span : leadSum)
                  : readRowQ;

  // calibration timer, counted from the sample-signal rise
  assign calLim   = CW'(cfgQ.calDly) + CW'(cfgQ.calLen);
  assign calT     = strb.calStart ? '0 : calCntQ;
  assign calPulse = (strb.calStart || calRunQ) && (calT >= CW'(cfgQ.calDly)) && (calT < calLim);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      calCntQ <= '0;
      calRunQ <= 1'b0;
    end else if (strb.calStart) begin
      calCntQ <= CW'(1);
      calRunQ <= 1'b1;
    end else if (calRunQ) begin
      if (calCntQ >= calLim) calRunQ <= 1'b0;
      else                   calCntQ <= calCntQ + CW'(1);
    end
  end

  assign loadLen = cfgQ.loadLen;
  assign sLen    = cfgQ.sLen;
  assign gapLen  = cfgQ.gapLen;
  assign rstLen  = cfgQ.rstLen;
  assign winLo   = cfgQ.winLo;
  assign winHi   = cfgQ.winHi;
endmodule

// File: rtl/rowseq_top.sv
module rowseq_top
  import rowseq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStart,
  input  logic              columnDone,
  input  logic [ROW_AW-1:0] winStart,
  input  logic [ROW_AW-1:0] winEnd,
  input  logic [ROW_AW-1:0] rowStep,
  input  logic [ROW_AW-1:0] leadOffset,
  input  logic [TIM_W-1:0]  loadCycles,
  input  logic [TIM_W-1:0]  sampleCycles,
  input  logic [TIM_W-1:0]  gapCycles,
  input  logic [TIM_W-1:0]  resetCycles,
  input  logic [TIM_W-1:0]  calDelay,
  input  logic [TIM_W-1:0]  calCycles,
  output logic [ROW_AW-1:0] rowAddr,
  output logic              rowLoadN,
  output logic              sampleS,
  output logic              rowReset,
  output logic              sampleR,
  output logic              calPulse,
  output logic              lineDone
);
  seqCfg_t cfgIn;
  seqStrobe_t strb;
  logic lastLine, frameAccept;
  logic [TIM_W-1:0] loadLen, sLen, gapLen, rstLen;
  logic [ROW_AW-1:0] winLoQ, winHiQ;

  assign cfgIn = '{winLo: winStart, winHi: winEnd, rowStep: rowStep, leadOff: leadOffset,
                   loadLen: loadCycles, sLen: sampleCycles, gapLen: gapCycles,
                   rstLen: resetCycles, calDly: calDelay, calLen: calCycles};
  assign frameAccept = strb.capture;

  rowseq_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .columnDone(columnDone),
    .lastLine(lastLine), .loadLen(loadLen), .sLen(sLen), .gapLen(gapLen),
    .rstLen(rstLen), .strb(strb), .rowLoadN(rowLoadN), .sampleS(sampleS),
    .rowReset(rowReset), .sampleR(sampleR), .lineDone(lineDone)
  );

  rowseq_dp uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgIn(cfgIn), .lastLine(lastLine),
    .rowAddr(rowAddr), .calPulse(calPulse), .loadLen(loadLen), .sLen(sLen),
    .gapLen(gapLen), .rstLen(rstLen), .winLo(winLoQ), .winHi(winHiQ)
  );
endmodule

// File: rtl/rowseq_chk.sv
module rowseq_chk
  import rowseq_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              columnDone,
  input logic [ROW_AW-1:0] rowAddr,
  input logic              rowLoadN,
  input logic              sampleS,
  input logic              rowReset,
  input logic              sampleR,
  input logic              calPulse,
  input logic              lineDone,
  input logic              frameAccept,
  input logic [ROW_AW-1:0] winLo,
  input logic [ROW_AW-1:0] winHi
);
  logic calSeenQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            calSeenQ <= 1'b0;
    else if (frameAccept) calSeenQ <= 1'b0;
    else if (calPulse)    calSeenQ <= 1'b1;
  end

  assert_one_strobe_R12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({~rowLoadN, sampleS, rowReset, sampleR}));

  assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (lineDone && !columnDone) |=> lineDone);

  assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    lineDone |-> (rowLoadN && !sampleS && !rowReset && !sampleR));

  assert_addr_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!rowLoadN && $past(!rowLoadN)) |-> $stable(rowAddr));

  assert_addr_window_R6: assert property (@(posedge clk) disable iff (!rstN)
    !rowLoadN |-> (rowAddr >= winLo && rowAddr <= winHi));

  assert_cal_once_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(calPulse) |-> !calSeenQ);

  assert_r_after_gap_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sampleR) |-> !$past(rowReset));

  assert_reset_after_load_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rowReset) |-> (rowLoadN && $past(rowLoadN)));
endmodule

bind rowseq_top rowseq_chk uChk (
  .clk(clk), .rstN(rstN), .columnDone(columnDone), .rowAddr(rowAddr),
  .rowLoadN(rowLoadN), .sampleS(sampleS), .rowReset(rowReset), .sampleR(sampleR),
  .calPulse(calPulse), .lineDone(lineDone), .frameAccept(frameAccept),
  .winLo(winLoQ), .winHi(winHiQ)
);

// File: tb/sim_rowseq_top.sv
module sim_rowseq_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, frameStart, columnDone;
  logic [9:0] winStart, winEnd, rowStep, leadOffset;
  logic [7:0] loadCycles, sampleCycles, gapCycles, resetCycles, calDelay, calCycles;
  logic [9:0] rowAddr;
  logic rowLoadN, sampleS, rowReset, sampleR, calPulse, lineDone;

  int checks = 0;
  int fails = 0;
  int calT = -1;
  int eDly = 0;
  int eCl = 1;
  string note = "";

  rowseq_top u0 (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .columnDone(columnDone),
    .winStart(winStart), .winEnd(winEnd), .rowStep(rowStep), .leadOffset(leadOffset),
    .loadCycles(loadCycles), .sampleCycles(sampleCycles), .gapCycles(gapCycles),
    .resetCycles(resetCycles), .calDelay(calDelay), .calCycles(calCycles),
    .rowAddr(rowAddr), .rowLoadN(rowLoadN), .sampleS(sampleS), .rowReset(rowReset),
    .sampleR(sampleR), .calPulse(calPulse), .lineDone(lineDone)
  );

  // compare one cycle of outputs, then move to the next falling edge
  task automatic cyc(input logic [9:0] eA, input logic eLd, input logic eS,
                     input logic eRst, input logic eR, input logic eDone, input string tag);
    logic [14:0] act, exp;
    logic eCal;
    act = {rowAddr, rowLoadN, sampleS, rowReset, sampleR, lineDone};
    exp = {eA, eLd, eS, eRst, eR, eDone};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, note, act, exp);
    end
    eCal = (calT >= 0) && (calT >= eDly) && (calT < eDly + eCl);
    checks++;
    if (calPulse !== eCal) begin
      fails++;
      $display("FAIL R9 calibration %s actual=%b expected=%b", note, calPulse, eCal);
    end
    if (calT >= 0) calT++;
    @(negedge clk);
  endtask

  function automatic int one(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic runFrame(input int ws, input int we, input int st, input int off,
                          input int ld, input int s, input int gp, input int rs,
                          input int cd, input int cl, input bit poke);
    int eSt, eLdL, eS, eG, eRs, span, rd, lead, waitN;
    bit first, last;
    eSt = one(st); eLdL = one(ld); eS = one(s); eG = one(gp); eRs = one(rs);
    span = we - ws + 1;
    winStart = 10'(ws); winEnd = 10'(we); rowStep = 10'(st); leadOffset = 10'(off);
    loadCycles = 8'(ld); sampleCycles = 8'(s); gapCycles = 8'(gp);
    resetCycles = 8'(rs); calDelay = 8'(cd); calCycles = 8'(cl);
    frameStart = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
    // R10: scramble every setting right after acceptance
    winStart = 10'd0; winEnd = 10'd1023; rowStep = 10'd5; leadOffset = 10'd9;
    loadCycles = 8'd3; sampleCycles = 8'd3; gapCycles = 8'd3;
    resetCycles = 8'd3; calDelay = 8'd3; calCycles = 8'd3;
    calT = -1; eDly = cd; eCl = one(cl);
    rd = ws; first = 1'b1;
    forever begin
      cyc(10'(rd), 1, 0, 0, 0, 0, "R7");
      repeat (eLdL) cyc(10'(rd), 0, 0, 0, 0, 0, "R3/R12");
      cyc(10'(rd), 1, 0, 0, 0, 0, "R3");
      if (first) calT = 0;
      repeat (eS)  cyc(10'(rd), 1, 1, 0, 0, 0, "R4/R12");
      repeat (eG)  cyc(10'(rd), 1, 0, 0, 0, 0, "R4");
      repeat (eRs) cyc(10'(rd), 1, 0, 1, 0, 0, "R4/R12");
      repeat (eG)  cyc(10'(rd), 1, 0, 0, 0, 0, "R4");
      repeat (eS)  cyc(10'(rd), 1, 0, 0, 1, 0, "R4/R12");
      lead = rd + off;
      if (lead > we) lead -= span;
      cyc(10'(lead), 1, 0, 0, 0, 0, "R6");
      repeat (eLdL) cyc(10'(lead), 0, 0, 0, 0, 0, "R6");
      cyc(10'(lead), 1, 0, 0, 0, 0, "R5");
      repeat (eG)  cyc(10'(lead), 1, 0, 0, 0, 0, "R5");
      repeat (eRs) cyc(10'(lead), 1, 0, 1, 0, 0, "R5");
      repeat (eG)  cyc(10'(lead), 1, 0, 0, 0, 0, "R5");
      waitN = 1 + (rd % 3);
      for (int k = 0; k < waitN; k++) begin
        if (poke && first && k == 0) frameStart = 1'b1;  // R2: ignored while busy
        if (k == waitN - 1) columnDone = 1'b1;
        cyc(10'(rd), 1, 0, 0, 0, 1, "R8");
        frameStart = 1'b0;
        columnDone = 1'b0;
      end
      last = (rd + eSt) > we;
      first = 1'b0;
      if (last) break;
      rd += eSt;
    end
    // R7: back to idle, bus keeps the last read row
    cyc(10'(rd), 1, 0, 0, 0, 0, "R7");
    cyc(10'(rd), 1, 0, 0, 0, 0, "R7");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0; frameStart = 1'b0; columnDone = 1'b0;
    winStart = '0; winEnd = '0; rowStep = '0; leadOffset = '0;
    loadCycles = '0; sampleCycles = '0; gapCycles = '0;
    resetCycles = '0; calDelay = '0; calCycles = '0;
    repeat (3) @(negedge clk);
    note = "R1 reset";
    cyc(10'd0, 1, 0, 0, 0, 0, "R1");
    rstN = 1'b1;
    columnDone = 1'b1;
    cyc(10'd0, 1, 0, 0, 0, 0, "R1");
    columnDone = 1'b0;
    cyc(10'd0, 1, 0, 0, 0, 0, "R1");

    // sweep step and lead offset over a six-row window, up to the full span
    for (int st = 1; st <= 3; st++) begin
      for (int off = 0; off <= 6; off++) begin
        note = (off == 0) ? "R2 R10 sweep" : "R10 sweep";
        runFrame(2, 7, st, off, 1 + off % 2, 1 + st, 1, 2, off, 1 + st % 2, off == 0);
      end
    end

    note = "R11 zero lengths";
    runFrame(10, 12, 0, 1, 0, 0, 0, 0, 0, 0, 1'b0);

    note = "R6 top wrap";
    runFrame(1020, 1023, 2, 3, 2, 1, 2, 1, 3, 2, 1'b0);

    note = "R7 single line";
    runFrame(500, 500, 1, 0, 1, 1, 1, 1, 0, 1, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule